// File: doc/BRIEF.md
# Self-Programming Flash Controller

This block is the control path a small processor core uses to rewrite its own program memory. The core writes an 8-bit control/status register over a simple register bus. It issues load-program-memory (LPM) and store-program-memory (SPM) strobes with a 16-bit Z address and a 16-bit data word. An SPM with only the enable bit set puts one word into a one-page staging buffer. An SPM armed for erase or write acts on a whole page of an internal program-memory array. LPM normally returns a byte of program memory. When an LPM arrives shortly after the core arms a signature read or a fuse/lock read, it returns a constant identification byte instead.

Each command is armed by writing its bit together with the enable bit. This opens a short window counted in clock cycles. The first matching strobe inside the window consumes the command. If no strobe matches, the register clears itself when the window ends. Erase and write walk the page one word per cycle. During that time `busy` is high and the block ignores all requests.

The controller has four states: `ST_IDLE` (no command armed), `ST_WINDOW` (command armed, counting cycles), `ST_ERASE` (page being filled with all ones) and `ST_PROGRAM` (staging buffer being copied into a page). Its transitions are:
- arm: `ST_IDLE` to `ST_WINDOW`, on a register write with enable set and a command other than buffer clear.
- consume or expire: `ST_WINDOW` to `ST_IDLE`.
- start erase: `ST_WINDOW` to `ST_ERASE`.
- start program: `ST_WINDOW` to `ST_PROGRAM`.
- finish: `ST_ERASE` or `ST_PROGRAM` to `ST_IDLE`, after the last word of the page.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset, `reg_rdata`, `busy`, `prog_fault` and `lpm_data` are zero, and every staging-buffer word holds 0xFFFF.
- R2: The control bits are: bit 5 signature read, bit 4 buffer clear, bit 3 fuse/lock read, bit 2 page write, bit 1 page erase, bit 0 enable. Bits 7:6 always read zero. A write with bit 0 clear leaves the register at zero. Writes are ignored while a window is open or `busy` is high. If several command bits are set, priority runs signature read, buffer clear, fuse/lock read, page write, page erase.
- R3: Z bits 6:1 select the word within a 64-word page, and Z bits 13:7 select the page (only the low log2(NUM_PAGES) of those bits are used). For a normal LPM, Z bit 0 selects the byte: 0 gives the low byte, 1 gives the high byte.
- R4: When a normal LPM is sampled on a clock edge, `lpm_data` shows the selected program-memory byte from that edge onward. `lpm_data` changes at no other time.
- R5: With only enable armed, an SPM sampled 1 to 4 cycles after the register write stores `spm_word` into the staging buffer at the Z word, and the register clears. An SPM arriving later has no effect.
- R6: If no matching strobe arrives, an armed command stays visible for 4 cycles after the write (3 for fuse/lock read), then the register clears. Later strobes act as if nothing was armed.
- R7: After signature read plus enable, an LPM 1 to 3 cycles later returns byte Z[2:1] of the SIG_ROW parameter (byte 0 = bits 7:0), and the register clears. An SPM within 4 cycles has no effect and does not consume the command.
- R8: After fuse/lock read plus enable, an LPM 1 to 3 cycles later returns LOCK_BYTE when Z bit 0 is 0 and FUSE_BYTE when it is 1.
- R9: Writing buffer clear plus enable sets every staging-buffer word to 0xFFFF at once, and the register stays zero.
- R10: An SPM inside a page-erase window sets every word of the Z page to 0xFFFF. `busy` is high for exactly 64 cycles, and the register keeps its bits until the erase is done.
- R11: An SPM inside a page-write window with Z word field zero copies the staging buffer into the Z page in 64 busy cycles. Afterwards every buffer word is 0xFFFF.
- R12: An SPM inside a page-write window with a nonzero word field changes no memory. It pulses `prog_fault` for one cycle, clears the register and leaves the buffer intact.
- R13: While `busy` is high, LPM, SPM and register writes are ignored, and `lpm_data` holds its value.
- R14: An LPM and an SPM in the same cycle are both served. The LPM is read or redirected, and the SPM acts according to the armed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| lpm_req | input | 1 | Load-program-memory strobe |
| spm_req | input | 1 | Store-program-memory strobe |
| zaddr | input | 16 | Z address: byte select, word and page fields |
| spm_word | input | 16 | Data word for buffer fill |
| lpm_data | output | 8 | Result byte of the last accepted LPM |
| busy | output | 1 | Page erase or page write in progress |
| prog_fault | output | 1 | One-cycle pulse on a rejected page write |

## Verification
The bench provokes two kinds of same-cycle overlap. First, it arms a plain buffer fill and raises LPM and SPM together on one Z address. It judges the result by the `lpm_data` byte from memory and by the buffer word, which becomes visible after a later page write. Second, it raises both strobes during a signature window. It expects the identification byte and an untouched buffer. The bench also sweeps the strobe arrival cycle across each window's edge, so an off-by-one in the window counter shows up as a wrong byte or a missing buffer word.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WINDOW,
        ST_ERASE,
        ST_PROGRAM
    } sp_state_t;

    typedef enum logic [2:0] {
        CMD_FILL,
        CMD_SIGREAD,
        CMD_CLRBUF,
        CMD_INFOREAD,
        CMD_PGWRITE,
        CMD_PGERASE
    } sp_cmd_t;

    localparam int BIT_EN    = 0;
    localparam int BIT_ERASE = 1;
    localparam int BIT_WRITE = 2;
    localparam int BIT_INFO  = 3;
    localparam int BIT_CLR   = 4;
    localparam int BIT_SIG   = 5;

    // Priority when several command bits are set
    function automatic sp_cmd_t decode_cmd(input logic [5:0] c);
        if (c[BIT_SIG])        return CMD_SIGREAD;
        else if (c[BIT_CLR])   return CMD_CLRBUF;
        else if (c[BIT_INFO])  return CMD_INFOREAD;
        else if (c[BIT_WRITE]) return CMD_PGWRITE;
        else if (c[BIT_ERASE]) return CMD_PGERASE;
        else                   return CMD_FILL;
    endfunction

endpackage

// File: rtl/selfprog_pagebuf.sv
module selfprog_pagebuf #(
    parameter int WORDS = 64,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [15:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);

    logic [15:0] slot_q [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < WORDS; i++) slot_q[i] <= 16'hFFFF;
        end else if (we) begin
            slot_q[waddr] <= wdata;
        end
    end

    assign rdata = slot_q[raddr];

endmodule

// File: rtl/selfprog_array.sv
module selfprog_array #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [15:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);

    logic [15:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cell_q[waddr] <= wdata;
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
    import selfprog_pkg::*;
#(
    parameter int          PAGE_WORDS = 64,
    parameter int          NUM_PAGES  = 8,
    parameter logic [31:0] SIG_ROW    = 32'hC3A5_1E69,
    parameter logic [7:0]  LOCK_BYTE  = 8'hFC,
    parameter logic [7:0]  FUSE_BYTE  = 8'hD6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        lpm_req,
    input  logic        spm_req,
    input  logic [15:0] zaddr,
    input  logic [15:0] spm_word,
    output logic [7:0]  lpm_data,
    output logic        busy,
    output logic        prog_fault
);

    localparam int WORD_AW = $clog2(PAGE_WORDS);
    localparam int PAGE_AW = $clog2(NUM_PAGES);
    localparam int MEM_AW  = WORD_AW + PAGE_AW;
    localparam int DEPTH   = PAGE_WORDS * NUM_PAGES;
    localparam logic [2:0]  LPM_WIN = 3'd3;
    localparam logic [2:0]  SPM_WIN = 3'd4;
    localparam logic [15:0] ERASED  = 16'hFFFF;
    localparam logic [WORD_AW-1:0] LAST_WORD = WORD_AW'(PAGE_WORDS - 1);

    sp_state_t          state_q, state_d;
    logic [5:0]         ctrl_q, ctrl_d;
    logic [2:0]         age_q, age_d;
    logic [WORD_AW-1:0] cnt_q, cnt_d;
    logic [PAGE_AW-1:0] page_q, page_d;
    logic [7:0]         lpm_q, lpm_d;
    logic               fault_q, fault_d;

    logic               win_close, win_start;
    logic               buf_we, buf_clr, mem_we;
    logic [15:0]        buf_rd, mem_rd, mem_wd;
    logic               busy_w;
    logic [2:0]         limit;
    sp_cmd_t            cmd_q, cmd_w;

    // Z address fields
    logic [WORD_AW-1:0] z_word;
    logic [PAGE_AW-1:0] z_page;
    logic               z_byte;
    assign z_word = zaddr[WORD_AW:1];
    assign z_page = zaddr[WORD_AW+1 +: PAGE_AW];
    assign z_byte = zaddr[0];

    logic unused_bits;
    assign unused_bits = ^{zaddr[15:WORD_AW+1+PAGE_AW], reg_wdata[7:6]};

    assign cmd_q  = decode_cmd(ctrl_q);
    assign cmd_w  = decode_cmd(reg_wdata[5:0]);
    assign busy_w = (state_q == ST_ERASE) || (state_q == ST_PROGRAM);
    assign limit  = (cmd_q == CMD_INFOREAD) ? LPM_WIN : SPM_WIN;

    logic [7:0] mem_byte, sig_byte, info_byte;
    assign mem_byte  = z_byte ? mem_rd[15:8] : mem_rd[7:0];
    assign sig_byte  = SIG_ROW[{zaddr[2:1], 3'b000} +: 8];
    assign info_byte = z_byte ? FUSE_BYTE : LOCK_BYTE;

    selfprog_pagebuf #(.WORDS(PAGE_WORDS), .AW(WORD_AW)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .we    (buf_we),
        .waddr (z_word),
        .wdata (spm_word),
        .raddr (cnt_q),
        .rdata (buf_rd)
    );

    selfprog_array #(.DEPTH(DEPTH), .AW(MEM_AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr ({page_q, cnt_q}),
        .wdata (mem_wd),
        .raddr ({z_page, z_word}),
        .rdata (mem_rd)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctrl_q  <= '0;
            age_q   <= '0;
            cnt_q   <= '0;
            page_q  <= '0;
            lpm_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ctrl_q  <= ctrl_d;
            age_q   <= age_d;
            cnt_q   <= cnt_d;
            page_q  <= page_d;
            lpm_q   <= lpm_d;
            fault_q <= fault_d;
        end
    end

    // Next state and actions
    always_comb begin
        state_d   = state_q;
        ctrl_d    = ctrl_q;
        age_d     = age_q;
        cnt_d     = cnt_q;
        page_d    = page_q;
        fault_d   = 1'b0;
        lpm_d     = lpm_q;
        win_close = 1'b0;
        win_start = 1'b0;
        buf_we    = 1'b0;
        buf_clr   = 1'b0;
        mem_we    = 1'b0;
        mem_wd    = ERASED;

        if (lpm_req && !busy_w) lpm_d = mem_byte;

        unique case (state_q)
            ST_IDLE: begin
                if (reg_wr && reg_wdata[BIT_EN]) begin
                    if (cmd_w == CMD_CLRBUF) begin
                        buf_clr = 1'b1;
                    end else begin
                        ctrl_d  = reg_wdata[5:0];
                        age_d   = 3'd1;
                        state_d = ST_WINDOW;
                    end
                end
            end
            ST_WINDOW: begin
                case (cmd_q)
                    CMD_FILL: if (spm_req) begin
                        buf_we    = 1'b1;
                        win_close = 1'b1;
                    end
                    CMD_SIGREAD: if (lpm_req && age_q <= LPM_WIN) begin
                        lpm_d     = sig_byte;
                        win_close = 1'b1;
                    end
                    CMD_INFOREAD: if (lpm_req) begin
                        lpm_d     = info_byte;
                        win_close = 1'b1;
                    end
                    CMD_PGERASE: if (spm_req) begin
                        page_d    = z_page;
                        cnt_d     = '0;
                        state_d   = ST_ERASE;
                        win_start = 1'b1;
                    end
                    CMD_PGWRITE: if (spm_req) begin
                        if (z_word == '0) begin
                            page_d    = z_page;
                            cnt_d     = '0;
                            state_d   = ST_PROGRAM;
                            win_start = 1'b1;
                        end else begin
                            fault_d   = 1'b1;
                            win_close = 1'b1;
                        end
                    end
                    default: win_close = 1'b1;
                endcase
                if (!win_start) begin
                    if (win_close || age_q == limit) begin
                        ctrl_d  = '0;
                        state_d = ST_IDLE;
                    end else begin
                        age_d = age_q + 3'd1;
                    end
                end
            end
            ST_ERASE: begin
                mem_we = 1'b1;
                mem_wd = ERASED;
                cnt_d  = cnt_q + 1'b1;
                if (cnt_q == LAST_WORD) begin
                    ctrl_d  = '0;
                    state_d = ST_IDLE;
                end
            end
            ST_PROGRAM: begin
                mem_we = 1'b1;
                mem_wd = buf_rd;
                cnt_d  = cnt_q + 1'b1;
                if (cnt_q == LAST_WORD) begin
                    buf_clr = 1'b1;
                    ctrl_d  = '0;
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    assign reg_rdata  = {2'b00, ctrl_q};
    assign lpm_data   = lpm_q;
    assign busy       = busy_w;
    assign prog_fault = fault_q;

endmodule

// File: rtl/selfprog_ctrl_chk.sv
module selfprog_ctrl_chk #(
    parameter int PAGE_WORDS = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       prog_fault,
    input logic       lpm_req,
    input logic [7:0] reg_rdata,
    input logic [7:0] lpm_data
);

    localparam int RUN_W = $clog2(PAGE_WORDS) + 2;

    logic [3:0]       open_cnt;
    logic [RUN_W-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_cnt <= '0;
            busy_run <= '0;
        end else begin
            if (reg_rdata != 8'h00 && !busy)
                open_cnt <= (open_cnt == 4'hF) ? open_cnt : open_cnt + 4'd1;
            else
                open_cnt <= '0;
            if (busy)
                busy_run <= (busy_run == '1) ? busy_run : busy_run + 1'b1;
            else
                busy_run <= '0;
        end
    end

    // R10
    busy_holds_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> reg_rdata[0]);

    // R10
    done_clears_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> reg_rdata == 8'h00);

    // R10
    busy_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RUN_W'(PAGE_WORDS));

    // R12
    fault_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_fault |-> (!busy && reg_rdata == 8'h00));

    // R6
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_cnt <= 4'd4);

    // R13
    busy_hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(lpm_data));

    // R4
    lpm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lpm_req |=> $stable(lpm_data));

endmodule

bind selfprog_ctrl selfprog_ctrl_chk #(.PAGE_WORDS(PAGE_WORDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .prog_fault (prog_fault),
    .lpm_req    (lpm_req),
    .reg_rdata  (reg_rdata),
    .lpm_data   (lpm_data)
);

// File: tb/selfprog_ctrl_test.sv
`timescale 1ns/1ps
module selfprog_ctrl_test;

    localparam int          PW    = 64;
    localparam int          NP    = 8;
    localparam logic [31:0] SIG   = 32'hC3A5_1E69;
    localparam logic [7:0]  LOCKB = 8'hFC;
    localparam logic [7:0]  FUSEB = 8'hD6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        lpm_req = 1'b0;
    logic        spm_req = 1'b0;
    logic [15:0] zaddr = '0;
    logic [15:0] spm_word = '0;
    logic [7:0]  lpm_data;
    logic        busy;
    logic        prog_fault;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [15:0] model [0:PW*NP-1];
    logic [15:0] bufm  [0:PW-1];

    always #2 clk = ~clk;

    selfprog_ctrl #(
        .PAGE_WORDS(PW), .NUM_PAGES(NP), .SIG_ROW(SIG),
        .LOCK_BYTE(LOCKB), .FUSE_BYTE(FUSEB)
    ) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .lpm_req(lpm_req), .spm_req(spm_req),
        .zaddr(zaddr), .spm_word(spm_word), .lpm_data(lpm_data),
        .busy(busy), .prog_fault(prog_fault)
    );

    function automatic logic [15:0] zf(input int p, input int w, input int b);
        return 16'((p << 7) | (w << 1) | b);
    endfunction

    function automatic logic [15:0] pat(input int p, input int w);
        return 16'((p * 16'h1357 + w * 16'h0A1B) ^ 16'h5A00);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic spm(input logic [15:0] z, input logic [15:0] w);
        spm_req = 1'b1; zaddr = z; spm_word = w;
        @(negedge clk);
        spm_req = 1'b0;
    endtask

    task automatic lpm(input logic [15:0] z, output logic [7:0] d);
        lpm_req = 1'b1; zaddr = z;
        @(negedge clk);
        lpm_req = 1'b0;
        d = lpm_data;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic fill(input int w, input logic [15:0] v);
        reg_write(8'h01);
        spm(zf(0, w, 0), v);
        bufm[w] = v;
    endtask

    task automatic do_erase(input int p);
        int n;
        reg_write(8'h03);
        spm(zf(p, 0, 0), 16'h0);
        wait_idle(n);
        chk(n == PW, "R10 erase busy cycles", n, PW);
        for (int w = 0; w < PW; w++) model[p*PW+w] = 16'hFFFF;
    endtask

    task automatic do_write(input int p);
        int n;
        reg_write(8'h05);
        spm(zf(p, 0, 0), 16'h0);
        wait_idle(n);
        chk(n == PW, "R11 write busy cycles", n, PW);
        for (int w = 0; w < PW; w++) begin
            model[p*PW+w] = bufm[w];
            bufm[w] = 16'hFFFF;
        end
    endtask

    task automatic check_page(input int p, input string tag);
        int errs;
        logic [7:0] d, e, fa, fe;
        errs = 0; fa = 0; fe = 0;
        for (int w = 0; w < PW; w++) begin
            for (int b = 0; b < 2; b++) begin
                lpm(zf(p, w, b), d);
                e = b ? model[p*PW+w][15:8] : model[p*PW+w][7:0];
                if (d !== e) begin
                    if (errs == 0) begin fa = d; fe = e; end
                    errs++;
                end
            end
        end
        chk(errs == 0, tag, fa, fe);
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] held;
        int n;

        for (int w = 0; w < PW; w++) bufm[w] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(reg_rdata == 8'h00, "R1 reg", reg_rdata, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(prog_fault == 1'b0, "R1 fault", prog_fault, 0);
        chk(lpm_data == 8'h00, "R1 lpm_data", lpm_data, 0);

        // R2 reserved bits, R6 window length
        reg_write(8'hC1);
        chk(reg_rdata == 8'h01, "R2 reserved read zero", reg_rdata, 8'h01);
        repeat (3) @(negedge clk);
        chk(reg_rdata == 8'h01, "R6 still armed at cycle 4", reg_rdata, 8'h01);
        @(negedge clk);
        chk(reg_rdata == 8'h00, "R6 expired", reg_rdata, 0);
        reg_write(8'h02);
        chk(reg_rdata == 8'h00, "R2 no enable ignored", reg_rdata, 0);

        // R10 erase every page
        for (int p = 0; p < NP; p++) do_erase(p);
        check_page(0, "R10 page0 erased");
        check_page(NP-1, "R10 last page erased");

        // R5 R11 R3 R4 fill and program every page, then read all bytes
        for (int p = 0; p < NP; p++) begin
            for (int w = 0; w < PW; w++) fill(w, pat(p, w));
            do_write(p);
        end
        for (int p = 0; p < NP; p++) check_page(p, "R4 R3 programmed page");

        // R11 buffer empty after write
        do_write(0);
        check_page(0, "R11 buffer reset after write");

        // R9 clear buffer
        fill(2, 16'h1234);
        fill(5, 16'h5678);
        reg_write(8'h11);
        chk(reg_rdata == 8'h00, "R9 register stays zero", reg_rdata, 0);
        for (int w = 0; w < PW; w++) bufm[w] = 16'hFFFF;
        do_write(1);
        check_page(1, "R9 cleared buffer programmed");

        // R7 signature sweep over index and arrival cycle
        for (int i = 0; i < 4; i++) begin
            for (int dl = 1; dl <= 4; dl++) begin
                logic [7:0] e;
                reg_write(8'h21);
                repeat (dl - 1) @(negedge clk);
                lpm(zf(2, i, 0), d);
                e = (dl <= 3) ? SIG[8*i +: 8] : model[2*PW+i][7:0];
                chk(d == e, "R7 signature read window", d, e);
                chk(reg_rdata == 8'h00, "R7 register cleared", reg_rdata, 0);
            end
        end

        // R7 SPM inside signature window has no effect
        reg_write(8'h21);
        spm(zf(0, 5, 0), 16'h1111);
        chk(reg_rdata == 8'h21, "R7 spm does not consume", reg_rdata, 8'h21);
        repeat (3) @(negedge clk);
        chk(reg_rdata == 8'h00, "R7 window ends", reg_rdata, 0);
        do_write(2);
        check_page(2, "R7 spm ignored in signature window");

        // R8 fuse/lock sweep
        for (int b = 0; b < 2; b++) begin
            for (int dl = 1; dl <= 4; dl++) begin
                logic [7:0] e;
                reg_write(8'h09);
                repeat (dl - 1) @(negedge clk);
                lpm(zf(3, 1, b), d);
                if (dl <= 3) e = b ? FUSEB : LOCKB;
                else         e = b ? model[3*PW+1][15:8] : model[3*PW+1][7:0];
                chk(d == e, "R8 fuse lock read window", d, e);
            end
        end

        // R5 fill window boundary
        reg_write(8'h01);
        repeat (3) @(negedge clk);
        spm(zf(0, 7, 0), 16'h7777);
        bufm[7] = 16'h7777;
        chk(reg_rdata == 8'h00, "R5 fill consumed at cycle 4", reg_rdata, 0);
        reg_write(8'h01);
        repeat (4) @(negedge clk);
        spm(zf(0, 8, 0), 16'h8888);
        do_write(5);
        check_page(5, "R5 fill window edge");

        // R12 rejected page write
        fill(0, 16'h0F0F);
        reg_write(8'h05);
        spm(zf(3, 1, 0), 16'h0);
        chk(prog_fault == 1'b1, "R12 fault pulse", prog_fault, 1);
        chk(busy == 1'b0, "R12 not busy", busy, 0);
        chk(reg_rdata == 8'h00, "R12 register cleared", reg_rdata, 0);
        @(negedge clk);
        chk(prog_fault == 1'b0, "R12 pulse one cycle", prog_fault, 0);
        check_page(3, "R12 memory unchanged");
        do_write(3);
        check_page(3, "R12 buffer kept");

        // R13 requests ignored while busy
        reg_write(8'h03);
        spm(zf(4, 0, 0), 16'h0);
        held = lpm_data;
        lpm(zf(6, 3, 0), d);
        chk(d == held, "R13 lpm ignored while busy", d, held);
        reg_write(8'h01);
        chk(reg_rdata == 8'h03, "R13 reg write ignored while busy", reg_rdata, 8'h03);
        spm(zf(0, 9, 0), 16'h9999);
        wait_idle(n);
        chk(reg_rdata == 8'h00, "R13 register clears after erase", reg_rdata, 0);
        for (int w = 0; w < PW; w++) model[4*PW+w] = 16'hFFFF;
        check_page(4, "R13 erase completes");

        // R14 LPM and SPM in the same cycle
        reg_write(8'h01);
        lpm_req = 1'b1; spm_req = 1'b1; zaddr = zf(6, 3, 0); spm_word = 16'hBEEF;
        @(negedge clk);
        lpm_req = 1'b0; spm_req = 1'b0;
        chk(lpm_data == model[6*PW+3][7:0], "R14 lpm with fill", lpm_data, model[6*PW+3][7:0]);
        bufm[3] = 16'hBEEF;
        reg_write(8'h21);
        lpm_req = 1'b1; spm_req = 1'b1; zaddr = zf(6, 3, 1); spm_word = 16'h2222;
        @(negedge clk);
        lpm_req = 1'b0; spm_req = 1'b0;
        chk(lpm_data == SIG[31:24], "R14 signature with spm", lpm_data, SIG[31:24]);
        do_write(7);
        check_page(7, "R14 buffer after simultaneous strobes");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R13 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule